// File: doc/BRIEF.md
# I2C Master SCL Timebase

This block produces the serial clock for an I2C master and frames each transfer with start and stop conditions. Two pairs of phase-count registers, one pair for standard mode and one for fast mode, set how many cycles of the block clock the line is held low and released high. A mode register picks the active pair. The count registers and the mode register accept writes only while the block is disabled.

A byte engine drives the block with single-cycle requests. A start request opens a transfer. Each bit request buys one high phase of SCL. A stop request closes the transfer. A request that arrives during a low phase is latched and served when that low phase expires. If no request is waiting, the block keeps SCL low. The sampled line level comes back on `scl_in`, so a target that holds SCL low (clock stretching) pauses the high-phase counter. `busy` reports that a transfer is in progress. `bit_done` tells the byte engine that the next data bit may be placed on SDA.

Top module: `scl_timebase`

## Requirements
- R1: Count registers are written with `cfg_we`: address 0 holds the standard high count, 1 the standard low count, 2 the fast high count, 3 the fast low count, and address 4 is the mode register. A write while `enable` is 1 is ignored. A write while `enable` is 0 takes effect.
- R2: A mode write takes its value from `cfg_wdata[2:0]`. Value 3'h2 selects the standard pair and 3'h4 selects the fast pair. Any other value leaves the mode unchanged. After reset the mode is standard.
- R3: A low phase holds `scl_drive_low` high for exactly low count + 1 cycles, counted from the cycle in which it first goes high, whenever the next request is already pending.
- R4: With no stretching, a data high phase releases SCL for exactly high count + 8 cycles.
- R5: After an accepted start request, `sda_cond_low` rises while SCL is still released. SCL stays released for high count + 3 cycles, and then `scl_drive_low` rises.
- R6: During a high phase, each cycle in which `scl_in` reads low after release stretches the phase by one cycle.
- R7: `busy` is 1 from the cycle after an accepted start until the stop ends. A start request made while `busy` is 1 has no effect.
- R8: With a stop pending at the end of a low phase, SCL is released for high count + 8 cycles. Then `sda_cond_low` and `busy` fall in the same cycle.
- R9: If a bit request and a stop request are both pending, the bit is served first. The stop follows after the next low phase.
- R10: `bit_done` is a one-cycle pulse in the first low cycle after each data high phase. It is never high while SCL is released.
- R11: After reset the block is idle with all outputs 0. With a 50 MHz counter clock, the default standard counts give at least 4.7 us low time and 4.0 us high time.
- R12: Clearing `enable` returns the block to idle by the next cycle. Both lines are released, and any pending request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; configuration writes are accepted only while low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select (0..4) |
| cfg_wdata | input | CW | Configuration write data |
| start_req | input | 1 | Open a transfer (accepted only when idle) |
| bit_req | input | 1 | Request one SCL high phase |
| stop_req | input | 1 | Request the stop condition |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_cond_low | output | 1 | Hold SDA low for start and stop framing |
| bit_done | output | 1 | Pulse: a data high phase has finished |
| busy | output | 1 | Transfer in progress |

## Verification
Two pairs of events can land on the same low-phase expiry. The first pair is a bit request and a stop request. The bench pulses both in one cycle during the start hold. It then expects exactly one `bit_done`, a second low phase of full length, and only after that a stop high phase of the programmed length. The second pair is a stretched release and the counter's own advance. The bench holds `scl_in` low from the first released cycle and expects the measured high phase to grow by exactly the number of held cycles.

// File: rtl/scl_timebase.sv
module scl_timebase #(
  parameter int CW      = 16,
  parameter int CLK_KHZ = 50000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          start_req,
  input  logic          bit_req,
  input  logic          stop_req,
  input  logic          scl_in,
  output logic          scl_drive_low,
  output logic          sda_cond_low,
  output logic          bit_done,
  output logic          busy
);

  localparam logic [CW-1:0] STD_HI0  = CW'((CLK_KHZ * 43 + 5000) / 10000 - 3);
  localparam logic [CW-1:0] STD_LO0  = CW'((CLK_KHZ * 50 + 5000) / 10000 - 1);
  localparam logic [CW-1:0] FAST_HI0 = CW'((CLK_KHZ * 9 + 5000) / 10000 - 3);
  localparam logic [CW-1:0] FAST_LO0 = CW'((CLK_KHZ * 16 + 5000) / 10000 - 1);
  localparam logic [2:0]    CODE_STD  = 3'h2;
  localparam logic [2:0]    CODE_FAST = 3'h4;

  typedef enum logic [2:0] {S_IDLE, S_START, S_LOW, S_HIGH, S_STOP} st_t;

  st_t            st;
  logic [CW:0]    cnt;
  logic [CW-1:0]  std_hi, std_lo, fast_hi, fast_lo;
  logic           fast_mode, pend_bit, pend_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_hi    <= STD_HI0;
      std_lo    <= STD_LO0;
      fast_hi   <= FAST_HI0;
      fast_lo   <= FAST_LO0;
      fast_mode <= 1'b0;
    end else if (cfg_we && !enable) begin
      case (cfg_addr)
        3'd0: std_hi  <= cfg_wdata;
        3'd1: std_lo  <= cfg_wdata;
        3'd2: fast_hi <= cfg_wdata;
        3'd3: fast_lo <= cfg_wdata;
        3'd4: begin
          if (cfg_wdata[2:0] == CODE_FAST)     fast_mode <= 1'b1;
          else if (cfg_wdata[2:0] == CODE_STD) fast_mode <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  wire [CW:0] hi_sel   = {1'b0, fast_mode ? fast_hi : std_hi};
  wire [CW:0] lo_sel   = {1'b0, fast_mode ? fast_lo : std_lo};
  wire        lo_end   = cnt == lo_sel;
  wire        hi_end   = cnt == hi_sel + (CW+1)'(7);
  wire        hold_end = cnt == hi_sel + (CW+1)'(2);
  wire        take_bit  = enable && st == S_LOW && lo_end && pend_bit;
  wire        take_stop = enable && st == S_LOW && lo_end && !pend_bit && pend_stop;
  wire        active    = enable && st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bit_done <= 1'b0;
    end else begin
      bit_done <= 1'b0;
      if (!enable) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          S_IDLE: if (start_req) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: if (scl_in) begin
            if (hold_end) begin
              st  <= S_LOW;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_LOW: begin
            if (!lo_end) cnt <= cnt + 1'b1;
            else if (take_bit) begin
              st  <= S_HIGH;
              cnt <= '0;
            end else if (take_stop) begin
              st  <= S_STOP;
              cnt <= '0;
            end
          end
          S_HIGH: if (scl_in) begin
            if (hi_end) begin
              st       <= S_LOW;
              cnt      <= '0;
              bit_done <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: if (scl_in) begin
            if (hi_end) begin
              st  <= S_IDLE;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_bit  <= 1'b0;
      pend_stop <= 1'b0;
    end else if (!active) begin
      pend_bit  <= 1'b0;
      pend_stop <= 1'b0;
    end else begin
      pend_bit  <= (pend_bit & ~take_bit) | bit_req;
      pend_stop <= (pend_stop & ~take_stop) | stop_req;
    end
  end

  assign scl_drive_low = st == S_LOW;
  assign sda_cond_low  = st != S_IDLE;
  assign busy          = st != S_IDLE;

  p_cfg_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable({std_hi, std_lo, fast_hi, fast_lo, fast_mode}));

  p_low_len_r3: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    $fell(scl_drive_low) |-> $past(cnt) == $past(lo_sel));

  p_stretch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    (busy && !scl_drive_low && !scl_in) |=> $stable(cnt));

  p_start_from_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req));

  p_done_in_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> scl_drive_low);

endmodule

// File: tb/scl_timebase_test.sv
module scl_timebase_test;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0, enable = 1'b0, cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          start_req = 1'b0, bit_req = 1'b0, stop_req = 1'b0, stretch = 1'b0;
  logic          scl_drive_low, sda_cond_low, bit_done, busy;
  wire           scl_in = !scl_drive_low && !stretch;

  scl_timebase #(.CW(CW), .CLK_KHZ(50000)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .start_req(start_req),
    .bit_req(bit_req), .stop_req(stop_req), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .sda_cond_low(sda_cond_low),
    .bit_done(bit_done), .busy(busy));

  int total = 0, bad = 0;
  bit finished = 1'b0;

  int run = 0, last_low = 0, last_high = 0, last_start = 0, last_stop = 0;
  int done_pulses = 0, done_bad = 0, sda_mismatch = 0;
  logic prev = 1'b0, seen_low = 1'b0, prev_done = 1'b0;

  always @(negedge clk) begin
    if (bit_done) begin
      done_pulses++;
      if (!scl_drive_low || prev_done) done_bad++;
    end
    prev_done = bit_done;
    if (sda_cond_low !== busy) sda_mismatch++;
    if (!busy) begin
      if (run != 0 && !prev) last_stop = run;
      run = 0; prev = 1'b0; seen_low = 1'b0;
    end else if (scl_drive_low == prev) run++;
    else begin
      if (prev) last_low = run;
      else if (seen_low) last_high = run;
      else last_start = run;
      run = 1;
      if (scl_drive_low) seen_low = 1'b1;
      prev = scl_drive_low;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input int act, input int lim);
    total++;
    if (act < lim) begin
      bad++;
      $display("FAIL %s: actual=%0d expected>=%0d", req, act, lim);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic run_frame(input int nbits, input int stretch_n);
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0; bit_req = 1'b1;
    @(negedge clk) bit_req = 1'b0;
    if (stretch_n > 0) begin
      while (!scl_drive_low) @(negedge clk);
      while (scl_drive_low) @(negedge clk);
      stretch = 1'b1;
      repeat (stretch_n) @(negedge clk);
      stretch = 1'b0;
    end
    for (int i = 0; i < nbits; i++) begin
      while (!bit_done) @(negedge clk);
      if (i < nbits - 1) bit_req = 1'b1; else stop_req = 1'b1;
      @(negedge clk); bit_req = 1'b0; stop_req = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset lines", {30'd0, scl_drive_low, sda_cond_low}, 0);
    chk("R11 reset bit_done", bit_done, 0);
  endtask

  task automatic t_defaults;
    enable = 1'b1;
    run_frame(1, 0);
    chk_ge("R11 default low >=4.7us", last_low, 235);
    chk_ge("R11 default high >=4.0us", last_high, 200);
    enable = 1'b0;
  endtask

  task automatic t_std_small;
    cfg_write(3'd0, 16'd5);
    cfg_write(3'd1, 16'd7);
    enable = 1'b1;
    run_frame(2, 0);
    chk("R5 start hold", last_start, 8);
    chk("R3 low phase", last_low, 8);
    chk("R4 high phase", last_high, 13);
    chk("R8 stop high", last_stop, 13);
  endtask

  task automatic t_stretch;
    run_frame(1, 6);
    chk("R6 stretched high", last_high, 19);
  endtask

  task automatic t_priority;
    int d0;
    d0 = done_pulses;
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0; bit_req = 1'b1; stop_req = 1'b1;
    @(negedge clk) bit_req = 1'b0; stop_req = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R9 one bit before stop", done_pulses - d0, 1);
    chk("R9 low before stop", last_low, 8);
    chk("R9 stop high", last_stop, 13);
  endtask

  task automatic t_start_ignored;
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    while (!scl_drive_low) @(negedge clk);
    repeat (10) @(negedge clk);
    start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 start while busy: scl held", scl_drive_low, 1);
    chk("R7 start while busy: busy", busy, 1);
    stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R7 busy drops after stop", busy, 0);
  endtask

  task automatic t_enable_drop;
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0; bit_req = 1'b1;
    @(negedge clk) bit_req = 1'b0;
    while (!scl_drive_low) @(negedge clk);
    while (scl_drive_low) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R12 idle after disable", {29'd0, busy, scl_drive_low, sda_cond_low}, 0);
    enable = 1'b1;
    repeat (30) @(negedge clk);
    chk("R12 no resume after re-enable", busy, 0);
  endtask

  task automatic t_locked_write;
    cfg_write(3'd0, 16'd40);
    run_frame(1, 0);
    chk("R1 write while enabled ignored", last_high, 13);
  endtask

  task automatic t_mode;
    enable = 1'b0;
    cfg_write(3'd2, 16'd3);
    cfg_write(3'd3, 16'd4);
    cfg_write(3'd4, 16'h4);
    enable = 1'b1;
    run_frame(1, 0);
    chk("R2 fast low", last_low, 5);
    chk("R2 fast high", last_high, 11);
    chk("R2 fast start hold", last_start, 6);
    enable = 1'b0;
    cfg_write(3'd4, 16'h7);
    enable = 1'b1;
    run_frame(1, 0);
    chk("R2 bad code ignored", last_high, 11);
    enable = 1'b0;
    cfg_write(3'd4, 16'h2);
    enable = 1'b1;
    run_frame(1, 0);
    chk("R2 back to standard", last_high, 13);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_defaults();
    t_std_small();
    t_stretch();
    t_priority();
    t_start_ignored();
    t_enable_drop();
    t_locked_write();
    t_mode();
    chk("R10 bit_done pulse shape", done_bad, 0);
    chk("R8 sda framing tracks busy", sda_mismatch, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule